// File: doc/BRIEF.md
# Branch Target Address Resolver

This block works out the new 20-bit program counter for an unconditional jump once the instruction has been decoded. The decoder presents an addressing mode, the instruction operand, the value of the selected register and the current program counter, then pulses `start`. In the direct modes the target is ready at once. In the memory modes the block first forms a pointer, then reads the target from memory as two 16-bit words.

For a memory mode the low half of the target comes from the word at the pointer. Bits 19:16 come from bits 3:0 of the word two bytes above the pointer. The memory port is synchronous, with a read latency of one cycle. When the target is complete the block writes it into its program counter register and raises `done` for one cycle. It has no path that writes the status flags or the mode bits, so a jump leaves them untouched. While the block is busy, any further `start` is ignored.

Top module: `branch_target_resolver`

## Requirements
- R1: While reset is low, and straight after it, `pcOut` is 0, `done` is 0, `busy` is 0 and `memRd` is 0.
- R2: Mode code 0 (immediate) loads `operand` into `pcOut` and issues no memory read. `done` and the new `pcOut` appear after the second rising edge, counting the edge that samples `start` as the first.
- R3: Mode code 3 (register) loads `regVal` into `pcOut`, with no memory read and the same two-edge timing as R2.
- R4: Mode code 1 (PC-relative) uses a pointer equal to `pcIn` plus `operand[15:0]` sign-extended to 20 bits, modulo 2^20.
- R5: Mode code 2 (absolute) uses `operand` as the pointer.
- R6: Mode code 4 (register indirect) uses `regVal` as the pointer.
- R7: In the memory modes, the first busy cycle reads address `pointer` and the second reads `pointer + 2` modulo 2^20. `memRd` is high only in those two cycles. The new `pcOut` and `done` appear after the fourth edge, counting the edge that samples `start` as the first.
- R8: The memory-mode target is {high word bits 3:0, low word}. High word bits 15:4 have no effect.
- R9: `done` is a single-cycle pulse and is high exactly in the cycles whose `pcOut` has just been updated. At all other times `pcOut` holds its value.
- R10: `busy` is high from the edge that accepts `start` until the edge that raises `done`. A `start` seen while `busy` is high is ignored, and inputs that change after the accepting edge have no effect.
- R11: The unused mode codes 5, 6 and 7 behave as immediate (R2).
- R12: A `start` presented in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving one jump |
| mode | input | 3 | Addressing mode code (see R2 to R6, R11) |
| operand | input | 20 | Immediate target, absolute pointer, or index in bits 15:0 |
| regVal | input | 20 | Value of the selected register |
| pcIn | input | 20 | Current program counter, used for PC-relative mode |
| memAddr | output | 20 | Memory read address |
| memRd | output | 1 | Memory read request |
| memRdata | input | 16 | Read data, valid one cycle after the request |
| pcOut | output | 20 | Program counter register |
| done | output | 1 | One-cycle pulse when `pcOut` has just been loaded |
| busy | output | 1 | A resolution is in progress |

## Verification
Two things can fall in the same cycle: the completion of one jump, with `done` high and `pcOut` freshly loaded, and the acceptance of the next `start`. The bench waits for `done` and raises `start` in that same cycle, once with a register-mode jump followed by an indirect one. The reference model has to accept the second request in that cycle, and it then has to see the following memory reads at the indirect pointer and the later `pcOut` match its own. A `start` sent mid-read checks the opposite case, where the request arrives while busy and must change nothing.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam logic [2:0] MODE_IMM = 3'd0;
  localparam logic [2:0] MODE_SYM = 3'd1;
  localparam logic [2:0] MODE_ABS = 3'd2;
  localparam logic [2:0] MODE_REG = 3'd3;
  localparam logic [2:0] MODE_IND = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ_LO = 2'd1,
    ST_READ_HI = 2'd2,
    ST_LOAD_PC = 2'd3
  } brtState_t;

  typedef struct packed {
    logic ldPtr;
    logic ldTarget;
    logic ldLo;
    logic ldPc;
    logic pcFromMem;
    logic memRd;
    logic selHiAddr;
  } brtStrobes_t;

  function automatic logic modeUsesMem(input logic [2:0] m);
    return (m == MODE_SYM) || (m == MODE_ABS) || (m == MODE_IND);
  endfunction
endpackage

// File: rtl/brt_ctrl.sv
module brt_ctrl
  import brt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  mode,
  output brtStrobes_t strobes,
  output logic        busy
);
  brtState_t stateQ, stateNext;
  logic memPathQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      memPathQ <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (stateQ == ST_IDLE && start) memPathQ <= modeUsesMem(mode);
    end
  end

  always_comb begin
    stateNext = stateQ;
    strobes   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          if (modeUsesMem(mode)) begin
            strobes.ldPtr = 1'b1;
            stateNext     = ST_READ_LO;
          end else begin
            strobes.ldTarget = 1'b1;
            stateNext        = ST_LOAD_PC;
          end
        end
      end
      ST_READ_LO: begin
        strobes.memRd = 1'b1;
        stateNext     = ST_READ_HI;
      end
      ST_READ_HI: begin
        strobes.memRd     = 1'b1;
        strobes.selHiAddr = 1'b1;
        strobes.ldLo      = 1'b1;
        stateNext         = ST_LOAD_PC;
      end
      ST_LOAD_PC: begin
        strobes.ldPc      = 1'b1;
        strobes.pcFromMem = memPathQ;
        stateNext         = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);
endmodule

// File: rtl/brt_datapath.sv
module brt_datapath
  import brt_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int WORD_W     = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  brtStrobes_t       strobes,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] operand,
  input  logic [ADDR_W-1:0] regVal,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic [ADDR_W-1:0] pcOut,
  output logic              done
);
  localparam int HI_W = ADDR_W - WORD_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] ptrQ, targetQ, pcQ;
  logic [ADDR_W-1:0] ptrNext, targetNext, indexExt;
  logic              doneQ;

  assign indexExt = {{HI_W{operand[WORD_W-1]}}, operand[WORD_W-1:0]};

  always_comb begin
    unique case (mode)
      MODE_SYM: ptrNext = pcIn + indexExt;
      MODE_IND: ptrNext = regVal;
      default:  ptrNext = operand;
    endcase
    targetNext = (mode == MODE_REG) ? regVal : operand;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ    <= '0;
      targetQ <= '0;
      pcQ     <= '0;
      doneQ   <= 1'b0;
    end else begin
      if (strobes.ldPtr)    ptrQ <= ptrNext;
      if (strobes.ldTarget) targetQ <= targetNext;
      if (strobes.ldLo)     targetQ[WORD_W-1:0] <= memRdata;
      doneQ <= strobes.ldPc;
      if (strobes.ldPc)
        pcQ <= strobes.pcFromMem ? {memRdata[HI_W-1:0], targetQ[WORD_W-1:0]} : targetQ;
    end
  end

  assign memAddr = strobes.selHiAddr ? ptrQ + STEP : ptrQ;
  assign memRd   = strobes.memRd;
  assign pcOut   = pcQ;
  assign done    = doneQ;
endmodule

// File: rtl/branch_target_resolver.sv
module branch_target_resolver
  import brt_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int WORD_W     = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] operand,
  input  logic [ADDR_W-1:0] regVal,
  input  logic [ADDR_W-1:0] pcIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic              done,
  output logic              busy
);
  brtStrobes_t strobes;

  brt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .strobes(strobes), .busy(busy)
  );

  brt_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORD_BYTES(WORD_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .mode(mode),
    .operand(operand), .regVal(regVal), .pcIn(pcIn), .memRdata(memRdata),
    .memAddr(memAddr), .memRd(memRd), .pcOut(pcOut), .done(done)
  );
endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
  parameter int ADDR_W     = 20,
  parameter int WORD_BYTES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] pcOut
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  a_r9_pc_holds: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(pcOut));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r7_read_busy: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> busy);
  a_r7_hi_step: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |-> memAddr == $past(memAddr) + STEP);
  a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> !busy);
endmodule

bind branch_target_resolver brt_checker #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_brtChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .memRd(memRd), .memAddr(memAddr), .pcOut(pcOut)
);

// File: tb/branch_target_resolver_bench.sv
module branch_target_resolver_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [19:0] operand = '0, regVal = '0, pcIn = '0;
  logic [19:0] memAddr, pcOut;
  logic        memRd, done, busy;
  logic [15:0] memRdata = '0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  branch_target_resolver u_branch_target_resolver (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .operand(operand),
    .regVal(regVal), .pcIn(pcIn), .memAddr(memAddr), .memRd(memRd),
    .memRdata(memRdata), .pcOut(pcOut), .done(done), .busy(busy)
  );

  logic [15:0] mem [int];

  function automatic logic [15:0] memRead(input logic [19:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  always @(posedge clk) if (memRd) memRdata <= memRead(memAddr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: remaining edges until done, pointer and pending target
  int          cnt = 0;
  bit          memOp = 0;
  bit          expDone = 0;
  logic [19:0] expPc = '0, ptr = '0, pend = '0;
  string       curTag = "R1";

  always @(posedge clk) begin
    if (!rstN) begin
      cnt = 0; memOp = 0; expDone = 0; expPc = '0;
    end else begin
      bit wasDone;
      wasDone = expDone;
      expDone = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin expDone = 1; expPc = pend; end
      end else if (start) begin
        memOp = 1;
        case (mode)
          3'd1: begin ptr = pcIn + {{4{operand[15]}}, operand[15:0]}; curTag = "R4 R8"; end
          3'd2: begin ptr = operand; curTag = "R5 R8"; end
          3'd4: begin ptr = regVal; curTag = "R6 R8"; end
          3'd3: begin memOp = 0; pend = regVal; curTag = "R3"; end
          3'd0: begin memOp = 0; pend = operand; curTag = "R2"; end
          default: begin memOp = 0; pend = operand; curTag = "R11"; end
        endcase
        if (memOp) begin
          logic [15:0] lo, hi;
          lo = memRead(ptr);
          hi = memRead(ptr + 20'd2);
          pend = {hi[3:0], lo};
          cnt = 3;
        end else cnt = 1;
        if (wasDone) curTag = {curTag, " R12"};
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      bit expRd;
      expRd = memOp && (cnt >= 2);
      chk(busy == (cnt > 0), "R10 busy", 32'(busy), 32'(cnt > 0));
      chk(done == expDone, "R9 done", 32'(done), 32'(expDone));
      chk(pcOut == expPc, curTag, 32'(pcOut), 32'(expPc));
      chk(memRd == expRd, "R7 memRd", 32'(memRd), 32'(expRd));
      if (expRd) chk(memAddr == (cnt == 3 ? ptr : ptr + 20'd2), "R7 memAddr",
                     32'(memAddr), 32'(cnt == 3 ? ptr : ptr + 20'd2));
    end
  end

  task automatic issue(input logic [2:0] m, input logic [19:0] op, input logic [19:0] rv, input logic [19:0] pc);
    @(negedge clk);
    start = 1; mode = m; operand = op; regVal = rv; pcIn = pc;
    @(negedge clk);
    start = 0; operand = 20'hABCDE; regVal = 20'h13579; pcIn = 20'h2468A; mode = 3'd2; // R10 later changes ignored
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
  endtask

  task automatic settle();
    for (int i = 0; i < 6; i++) @(negedge clk);
  endtask

  initial begin
    mem[20'h0FFF0] = 16'h1234; mem[20'h0FFF2] = 16'hFFF5;   // R8 junk upper bits
    mem[20'h00010] = 16'hBEEF; mem[20'h00012] = 16'h0003;
    mem[20'hFFFFE] = 16'h4321; mem[20'h00000] = 16'hA00C;   // R7 wrap
    mem[20'h20400] = 16'h0F0F; mem[20'h20402] = 16'h0009;
    mem[20'h30000] = 16'h5555; mem[20'h30002] = 16'h0001;

    repeat (3) @(negedge clk);
    chk(pcOut == 0 && !done && !busy && !memRd, "R1 reset", {pcOut, 3'b0, done, busy, memRd}, 0);
    rstN = 1;
    @(negedge clk);
    chk(pcOut == 0 && !busy, "R1 after reset", 32'(pcOut), 0);

    issue(3'd0, 20'h1AA04, 20'h0, 20'h0); settle();          // R2
    issue(3'd3, 20'h0, 20'h54321, 20'h0); settle();          // R3
    issue(3'd1, 20'h0FFF0, 20'h0, 20'h10000); settle();      // R4 negative index, R8
    issue(3'd1, 20'h00020, 20'h0, 20'hFFFF0); settle();      // R4 wrap
    issue(3'd2, 20'hFFFFE, 20'h0, 20'h0); settle();          // R5, R7 +2 wrap
    issue(3'd4, 20'h0, 20'h20400, 20'h0); settle();          // R6
    issue(3'd6, 20'h0BEAD, 20'h0, 20'h0); settle();          // R11
    issue(3'd7, 20'hFEED1, 20'h0, 20'h0); settle();          // R11

    // R10: a start while busy is ignored
    issue(3'd2, 20'h30000, 20'h0, 20'h0);
    start = 1; mode = 3'd0; operand = 20'h77777;
    @(negedge clk); start = 0;
    settle();
    chk(pcOut == 20'h15555, "R10 ignored start", 32'(pcOut), 32'h15555);

    // R12: start in the done cycle
    issue(3'd3, 20'h0, 20'h0ABCD, 20'h0);
    waitDone();
    start = 1; mode = 3'd4; regVal = 20'h20400;
    @(negedge clk); start = 0;
    settle();
    chk(pcOut == 20'h90F0F, "R12 back-to-back", 32'(pcOut), 32'h90F0F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule